// File: doc/BRIEF.md
# Slave-Port Arbiter with Slot Limit

This block decides which of up to eight bus masters owns a single shared slave port. Masters raise per-master request lines. The owner holds a burst-busy line high while it is in the middle of a burst. When that line falls, the access has reached a boundary and the port arbitrates again. Among several requesters the choice is round-robin. The search starts at the master after the one most recently picked from requests.

A programmable slot limit caps how long an owner may keep the port while it transfers. Once the limit is reached, the burst is cut only if some other master is waiting. Otherwise the owner continues. A park policy decides what happens when nobody requests. The port can disconnect from all masters, stay with the last owner, or connect to a configured master. A parked master's next access starts with no arbitration cycle. Any other master needs one cycle to be connected.

The enclosing fabric drives the configuration fields and consumes the one-hot grant. It also uses the owner index to steer its data path, and the break pulse to end the interrupted burst.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset, grantVec is all zero, idleFlag is 1 and breakPulse is 0.
- R2: grantVec is one-hot or zero. When it is non-zero, bit ownerIdx is the set bit. idleFlag is 1 exactly when grantVec is zero.
- R3: Arbitration happens on the clock edge after any cycle in which the port is disconnected or burstBusy is 0. If reqVec is non-zero at that edge, the grant goes to the first requesting master in the order ptr+1, ptr+2, … (modulo 8). Here ptr is the index last granted from a request, and it is 7 after reset.
- R4: While the owner holds burstBusy high and no other master requests, the grant does not change, however long the burst lasts.
- R5: Suppose slotLimit is L (non-zero) and the owner keeps burstBusy high from the cycle after its grant. If another master requests throughout, the grant moves on the (L+1)-th edge after the grant was given. It moves to the round-robin winner among the other requesters.
- R6: With slotLimit 0, no burst is ever broken: no breakPulse occurs and the owner keeps the port while burstBusy is high.
- R7: parkMode 0: at an arbitration with reqVec zero, the port disconnects (grantVec becomes zero).
- R8: parkMode 1: at an arbitration with reqVec zero, the grant stays on the current owner, or stays empty if nobody was connected.
- R9: parkMode 2: at an arbitration with reqVec zero, the grant goes to master parkIdx. That master is then already granted when it starts an access.
- R10: parkMode 3 behaves exactly as parkMode 0.
- R11: The slot counter advances only in cycles where the owner holds burstBusy high. It is cleared at every arbitration. Time spent idle or parked therefore never shortens the next burst's slot.
- R12: breakPulse is high for exactly one cycle, in the cycle where the grant first shows the new owner after a slot break. It is never high on an ordinary handover at a burst boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | 8 | Per-master request lines |
| burstBusy | input | 1 | Current owner is inside a burst; 0 marks an access boundary |
| slotLimit | input | 9 | Slot length in cycles; 0 disables the limit |
| parkMode | input | 2 | Idle policy: 0 none, 1 last owner, 2 fixed master, 3 as 0 |
| parkIdx | input | 3 | Master used by park mode 2 |
| grantVec | output | 8 | One-hot grant |
| ownerIdx | output | 3 | Index of the connected master (0 when idle) |
| breakPulse | output | 1 | One-cycle flag that the previous burst was cut |
| idleFlag | output | 1 | No master is connected |

## Verification
The hardest situation to reach is a slot break that lands exactly on the counter limit after a long idle or parked stretch. The proof that idle time is not counted only shows in the cycle the break occurs. The stimulus parks the port on a fixed master for many cycles. It then starts a busy burst with a competitor already requesting, and counts edges until the grant moves. It repeats this for several limits and competitors, and compares the count with L+1.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_ALT   = 2'd3
  } parkMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;     // arbitration: zero the slot counter
    logic incCnt;     // owner transferring: advance counter
    logic takeReq;    // load grant from request winner
    logic onlyOthers; // winner excludes current owner (slot break)
    logic parkFixed;  // connect configured park master
    logic parkNone;   // disconnect everyone
    logic markBreak;  // raise break flag with the new grant
  } arbStrobe_t;

endpackage

// File: rtl/slvarb_rr_pick.sv
module slvarb_rr_pick #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand,
  input  logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] winIdx,
  output logic             found
);
  always_comb begin
    found  = 1'b0;
    winIdx = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!found && cand[idx]) begin
        found  = 1'b1;
        winIdx = IDX_W'(idx);
      end
    end
  end
endmodule

// File: rtl/slvarb_ctrl.sv
module slvarb_ctrl
  import slvarb_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 9
) (
  input  logic [N-1:0]     reqVec,
  input  logic             burstBusy,
  input  logic [CNT_W-1:0] slotLimit,
  input  logic [1:0]       parkMode,
  input  logic [CNT_W-1:0] slotCnt,
  input  logic [N-1:0]     grantVec,
  output arbStrobe_t       strobe
);
  logic connected, anyReq, anyOther, expire, breakNow, rearb;
  parkMode_e mode;

  always_comb begin
    mode      = parkMode_e'(parkMode);
    connected = |grantVec;
    anyReq    = |reqVec;
    anyOther  = |(reqVec & ~grantVec);
    expire    = connected && burstBusy && (slotLimit != '0) && (slotCnt >= slotLimit);
    breakNow  = expire && anyOther;
    rearb     = !connected || !burstBusy || breakNow;

    strobe            = '0;
    strobe.clrCnt     = rearb;
    strobe.incCnt     = !rearb;
    strobe.takeReq    = rearb && (breakNow || anyReq);
    strobe.onlyOthers = breakNow;
    strobe.markBreak  = breakNow;
    strobe.parkFixed  = rearb && !anyReq && (mode == PARK_FIXED);
    strobe.parkNone   = rearb && !anyReq && ((mode == PARK_NONE) || (mode == PARK_ALT));
  end
endmodule

// File: rtl/slvarb_datapath.sv
module slvarb_datapath
  import slvarb_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 9,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqVec,
  input  logic [IDX_W-1:0] parkIdx,
  input  arbStrobe_t       strobe,
  output logic [N-1:0]     grantVec,
  output logic [IDX_W-1:0] ownerIdx,
  output logic [CNT_W-1:0] slotCnt,
  output logic             breakPulse
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] winIdx;
  logic             winFound;
  logic [N-1:0]     cand;
  logic             parkValid;

  assign cand      = strobe.onlyOthers ? (reqVec & ~grantVec) : reqVec;
  assign parkValid = int'(parkIdx) < N;

  slvarb_rr_pick #(.N(N), .IDX_W(IDX_W)) uPick (
    .cand  (cand),
    .ptr   (ptr),
    .winIdx(winIdx),
    .found (winFound)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantVec   <= '0;
      ownerIdx   <= '0;
      ptr        <= IDX_W'(N - 1);
      slotCnt    <= '0;
      breakPulse <= 1'b0;
    end else begin
      breakPulse <= strobe.markBreak;
      if (strobe.clrCnt)
        slotCnt <= '0;
      else if (strobe.incCnt && !(&slotCnt))
        slotCnt <= slotCnt + 1'b1;

      if (strobe.takeReq && winFound) begin
        grantVec <= ONE << winIdx;
        ownerIdx <= winIdx;
        ptr      <= winIdx;
      end else if (strobe.parkFixed) begin
        grantVec <= parkValid ? (ONE << parkIdx) : '0;
        ownerIdx <= parkValid ? parkIdx : '0;
      end else if (strobe.parkNone) begin
        grantVec <= '0;
        ownerIdx <= '0;
      end
    end
  end
endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import slvarb_pkg::*;
#(
  parameter int N     = 8,
  parameter int CNT_W = 9,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqVec,
  input  logic             burstBusy,
  input  logic [CNT_W-1:0] slotLimit,
  input  logic [1:0]       parkMode,
  input  logic [IDX_W-1:0] parkIdx,
  output logic [N-1:0]     grantVec,
  output logic [IDX_W-1:0] ownerIdx,
  output logic             breakPulse,
  output logic             idleFlag
);
  arbStrobe_t       strobe;
  logic [CNT_W-1:0] slotCnt;

  slvarb_ctrl #(.N(N), .CNT_W(CNT_W)) uCtrl (
    .reqVec   (reqVec),
    .burstBusy(burstBusy),
    .slotLimit(slotLimit),
    .parkMode (parkMode),
    .slotCnt  (slotCnt),
    .grantVec (grantVec),
    .strobe   (strobe)
  );

  slvarb_datapath #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .parkIdx   (parkIdx),
    .strobe    (strobe),
    .grantVec  (grantVec),
    .ownerIdx  (ownerIdx),
    .slotCnt   (slotCnt),
    .breakPulse(breakPulse)
  );

  assign idleFlag = ~|grantVec;
endmodule

// File: rtl/slvarb_checker.sv
module slvarb_checker #(
  parameter int N     = 8,
  parameter int CNT_W = 9,
  parameter int IDX_W = $clog2(N)
) (
  input logic             clk,
  input logic             rstN,
  input logic [N-1:0]     reqVec,
  input logic             burstBusy,
  input logic [CNT_W-1:0] slotLimit,
  input logic [1:0]       parkMode,
  input logic [IDX_W-1:0] parkIdx,
  input logic [N-1:0]     grantVec,
  input logic [IDX_W-1:0] ownerIdx,
  input logic             breakPulse,
  input logic             idleFlag
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  assert_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0) |-> grantVec[ownerIdx]);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((grantVec != '0) && burstBusy && ((reqVec & ~grantVec) == '0)) |=> $stable(grantVec));

  assert_break_moves_R5: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |-> (grantVec != $past(grantVec)));

  assert_no_break_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slotLimit == '0) |=> !breakPulse);

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!burstBusy && (reqVec == '0) && ((parkMode == 2'd0) || (parkMode == 2'd3)))
      |=> (grantVec == '0));

  assert_stay_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((parkMode == 2'd1) && (reqVec == '0)) |=> $stable(grantVec));

  assert_fixed_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((parkMode == 2'd2) && (reqVec == '0) && !burstBusy)
      |=> ((grantVec != '0) && (ownerIdx == $past(parkIdx))));

  assert_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |=> !breakPulse);
endmodule

bind slave_port_arbiter slvarb_checker #(.N(N), .CNT_W(CNT_W), .IDX_W(IDX_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqVec    (reqVec),
  .burstBusy (burstBusy),
  .slotLimit (slotLimit),
  .parkMode  (parkMode),
  .parkIdx   (parkIdx),
  .grantVec  (grantVec),
  .ownerIdx  (ownerIdx),
  .breakPulse(breakPulse),
  .idleFlag  (idleFlag)
);

// File: tb/sim_slave_port_arbiter.sv
`timescale 1ns/1ps
module sim_slave_port_arbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqVec = '0;
  logic       burstBusy = 1'b0;
  logic [8:0] slotLimit = '0;
  logic [1:0] parkMode = '0;
  logic [2:0] parkIdx = '0;
  logic [7:0] grantVec;
  logic [2:0] ownerIdx;
  logic       breakPulse;
  logic       idleFlag;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk; // 125 MHz

  slave_port_arbiter u0 (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .burstBusy(burstBusy),
    .slotLimit(slotLimit), .parkMode(parkMode), .parkIdx(parkIdx),
    .grantVec(grantVec), .ownerIdx(ownerIdx), .breakPulse(breakPulse),
    .idleFlag(idleFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    reqVec = '0; burstBusy = 1'b0; rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  // Counts edges until the grant leaves oldG (limit 40)
  task automatic edgesToMove(input logic [7:0] oldG, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (grantVec == oldG && n < 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    int ptrM;
    // R1 reset state
    doReset();
    check("R1 grant", grantVec, 0);
    check("R1 idle", idleFlag, 1);
    check("R1 break", breakPulse, 0);

    // R3 round-robin sweep over every request mask, boundary each cycle
    ptrM = 7;
    for (int m = 1; m < 256; m++) begin
      for (int r = 0; r < 2; r++) begin
        int win;
        win = 0;
        reqVec = 8'(m);
        step();
        for (int k = 8; k >= 1; k--)
          if (m[(ptrM + k) % 8]) win = (ptrM + k) % 8;
        ptrM = win;
        check("R3 grant", grantVec, 1 << win);
        check("R2 owner", ownerIdx, win);
        check("R2 idle", idleFlag, 0);
        check("R12 no break on handover", breakPulse, 0);
      end
    end
    reqVec = '0;
    step();
    check("R7 disconnect", grantVec, 0);
    check("R2 idle set", idleFlag, 1);

    // R5 / R12 / R8 slot break for several limits
    for (int lim = 1; lim <= 6; lim++) begin
      int comp;
      comp = (lim + 2) % 8;
      doReset();
      slotLimit = 9'(lim); parkMode = 2'd1;
      reqVec = 8'h04; step();
      check("R3 first grant", grantVec, 8'h04);
      burstBusy = 1'b1;
      reqVec = 8'h04 | (8'h01 << comp);
      edgesToMove(8'h04, n);
      check("R5 break edge", n, lim + 1);
      check("R5 new owner", grantVec, 1 << comp);
      check("R12 pulse", breakPulse, 1);
      step();
      check("R12 single", breakPulse, 0);
      burstBusy = 1'b0; reqVec = '0; step();
      check("R8 stay last", grantVec, 1 << comp);
      repeat (5) step();
      check("R8 still", grantVec, 1 << comp);
    end

    // R11 long park does not consume the slot; R9 parked master
    for (int lim = 2; lim <= 5; lim++) begin
      doReset();
      slotLimit = 9'(lim); parkMode = 2'd2; parkIdx = 3'd3;
      step();
      check("R9 parked", grantVec, 8'h08);
      repeat (30) step();
      check("R9 parked hold", grantVec, 8'h08);
      burstBusy = 1'b1; reqVec = 8'h48;
      edgesToMove(8'h08, n);
      check("R11 full slot", n, lim + 1);
      check("R11 new owner", grantVec, 8'h40);
      burstBusy = 1'b0; reqVec = '0; step();
      check("R9 return to park", grantVec, 8'h08);
    end

    // R6 limit zero never breaks
    doReset();
    slotLimit = '0; parkMode = 2'd0;
    reqVec = 8'h02; step();
    burstBusy = 1'b1; reqVec = 8'h83;
    n = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (grantVec != 8'h02 || breakPulse) n++;
    end
    check("R6 no break", n, 0);

    // R4 owner alone keeps port past the limit
    doReset();
    slotLimit = 9'd3; burstBusy = 1'b0;
    reqVec = 8'h02; step();
    burstBusy = 1'b1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (grantVec != 8'h02 || breakPulse) n++;
    end
    check("R4 hold", n, 0);

    // R7 R8 R9 R10 park mode sweep
    slotLimit = '0;
    for (int md = 0; md < 4; md++) begin
      for (int p = 0; p < 8; p++) begin
        int q, e0, e1;
        q = (p + 1) % 8;
        doReset();
        parkMode = 2'(md); parkIdx = 3'(p);
        step();
        e0 = (md == 2) ? (1 << p) : 0;
        check(md == 2 ? "R9 idle park" : "R10 idle none", grantVec, e0);
        check("R2 idle flag", idleFlag, e0 == 0);
        reqVec = 8'(1 << q); step();
        check("R3 grant", grantVec, 1 << q);
        reqVec = '0; step();
        e1 = (md == 1) ? (1 << q) : (md == 2) ? (1 << p) : 0;
        if (md == 1) check("R8 last", grantVec, e1);
        else if (md == 2) check("R9 fixed", grantVec, e1);
        else if (md == 3) check("R10 as none", grantVec, e1);
        else check("R7 none", grantVec, e1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule